// File: doc/BRIEF.md
# Dual-Channel Zoned Address Mapper

This block translates a flat physical byte address into a channel choice and a channel-local byte address. It serves a memory controller with two channels, A and B, whose capacities may differ. Both capacities are configured in 64-byte line units. The lowest part of the flat space is an interleaved zone. In that zone, neighbouring 64-byte lines go to alternate channels. It covers twice the capacity of the smaller channel, B. Any capacity that A has beyond B is mapped linearly, to A only, directly above the interleaved zone. Addresses beyond the combined capacity are reported as out of range. A configuration where B is larger than A is reported as invalid.

Requests come in on a valid/ready port and results leave on a valid/ready port. A single output register sits between them. A request is taken on a rising clock edge when `req_valid` and `req_ready` are both high. Its result appears on the next cycle. The result is held, unchanged, for as long as `res_ready` stays low. `req_ready` is high when the output register is empty or is being drained in the same cycle. One request can therefore be accepted on every cycle. The configuration inputs are plain levels. They may change only while no request is offered and no result is pending.

Top module: `zoned_addr_mapper`

## Requirements
- R1: A request whose line index L (address bits above bit 5) satisfies L < 2*lines_b falls in the interleaved zone. Address bit 6 picks the channel: 0 gives `res_sel`=2'b01 (A) and 1 gives `res_sel`=2'b10 (B). `res_local` is the address with bit 6 removed, the upper bits shifted down one place and the top bit zero. `res_sym`=1 and `res_err`=0.
- R2: A request with 2*lines_b <= L < lines_a+lines_b goes to A (`res_sel`=2'b01), with `res_sym`=0 and `res_err`=0. `res_local` line index is L-lines_b and its bits 5:0 equal those of the request.
- R3: A request with L >= lines_a+lines_b returns `res_err`=1, `res_sel`=2'b00, `res_local`=0 and `res_sym`=0.
- R4: When lines_b > lines_a, `cfg_bad`=1 and every result has `res_err`=1, `res_sel`=2'b00, `res_local`=0 and `res_sym`=0. Otherwise `cfg_bad`=0.
- R5: With lines_b=0 and lines_a>0, every in-range address goes to A with `res_local` equal to the request address.
- R6: With lines_a=lines_b>0, every in-range address is interleaved and no address yields `res_sym`=0 without `res_err`.
- R7: A request accepted on an edge makes `res_valid`=1 with its result right after that edge.
- R8: While `res_valid`=1 and `res_ready`=0, `req_ready`=0 and the result outputs hold steady. `req_ready`=1 whenever `res_valid`=0.
- R9: The configuration inputs stay unchanged on any edge where `req_valid` or `res_valid` is high.
- R10: After reset, `res_valid`=0 and `req_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cfg_lines_a | input | LINE_W | Capacity of channel A in 64-byte lines |
| cfg_lines_b | input | LINE_W | Capacity of channel B in 64-byte lines |
| cfg_bad | output | 1 | Configuration invalid (B larger than A) |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_addr | input | ADDR_W | Flat byte address |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result |
| res_sel | output | 2 | One-hot channel: bit 0 = A, bit 1 = B, zero on error |
| res_local | output | ADDR_W | Channel-local byte address |
| res_sym | output | 1 | Address lies in the interleaved zone |
| res_err | output | 1 | Out of range or invalid configuration |

## Verification
A wrong zone boundary at the ports shows up on the first address past the boundary. It appears as a wrong `res_sym`, a wrong select, or a local line that is off by lines_b, and it is visible in the result cycle of that very request. A wrong line offset in the linear zone shows on every request in that zone. A broken output register shows up either as a result changing under back-pressure or as `res_valid` missing one cycle after acceptance. Both appear within a cycle of the stall or the acceptance. The bench sweeps every pair of channel sizes and every line of a 16-line space, so each such fault reaches the ports under at least one configuration.

// File: rtl/zmap_pkg.sv
package zmap_pkg;
  localparam int OFF_W = 6;
  localparam logic [1:0] SEL_A = 2'b01;
  localparam logic [1:0] SEL_B = 2'b10;
  localparam logic [1:0] SEL_NONE = 2'b00;

  typedef enum logic [1:0] {
    ZN_SYM = 2'd0,
    ZN_LIN = 2'd1,
    ZN_OOR = 2'd2,
    ZN_BAD = 2'd3
  } zone_e;
endpackage

// File: rtl/zmap_cfg_check.sv
module zmap_cfg_check #(
  parameter int LINE_W = 10
) (
  input  logic [LINE_W-1:0] lines_a,
  input  logic [LINE_W-1:0] lines_b,
  output logic              bad,
  output logic [LINE_W:0]   sym_top,
  output logic [LINE_W:0]   total
);
  always_comb begin
    bad     = (lines_b > lines_a);
    sym_top = {lines_b, 1'b0};
    total   = {1'b0, lines_a} + {1'b0, lines_b};
  end
endmodule

// File: rtl/zmap_zone_classify.sv
module zmap_zone_classify
  import zmap_pkg::*;
#(
  parameter int LINE_W = 10
) (
  input  logic [LINE_W-1:0] line,
  input  logic [LINE_W:0]   sym_top,
  input  logic [LINE_W:0]   total,
  input  logic              bad,
  output zone_e             zone
);
  logic [LINE_W:0] line_x;

  always_comb begin
    line_x = {1'b0, line};
    if (bad)                  zone = ZN_BAD;
    else if (line_x >= total) zone = ZN_OOR;
    else if (line_x < sym_top) zone = ZN_SYM;
    else                      zone = ZN_LIN;
  end
endmodule

// File: rtl/zmap_addr_remap.sv
module zmap_addr_remap
  import zmap_pkg::*;
#(
  parameter int ADDR_W = 16,
  localparam int LINE_W = ADDR_W - OFF_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  zone_e             zone,
  input  logic [LINE_W-1:0] lines_b,
  output logic [1:0]        sel,
  output logic [ADDR_W-1:0] local_addr,
  output logic              sym,
  output logic              err
);
  logic [ADDR_W-1:0] il_addr;
  logic [ADDR_W-1:0] lin_addr;

  // interleaved local address: drop the channel bit, shift the rest down
  for (genvar i = 0; i < ADDR_W; i++) begin : g_squeeze
    if (i < OFF_W) begin : g_low
      assign il_addr[i] = addr[i];
    end else if (i < ADDR_W - 1) begin : g_mid
      assign il_addr[i] = addr[i+1];
    end else begin : g_top
      assign il_addr[i] = 1'b0;
    end
  end

  // linear zone: line - 2*b + b
  assign lin_addr = {addr[ADDR_W-1:OFF_W] - lines_b, addr[OFF_W-1:0]};

  always_comb begin
    sel        = SEL_NONE;
    local_addr = '0;
    sym        = 1'b0;
    err        = 1'b0;
    unique case (zone)
      ZN_SYM: begin
        sel        = addr[OFF_W] ? SEL_B : SEL_A;
        local_addr = il_addr;
        sym        = 1'b1;
      end
      ZN_LIN: begin
        sel        = SEL_A;
        local_addr = lin_addr;
      end
      default: err = 1'b1;
    endcase
  end
endmodule

// File: rtl/zmap_out_stage.sv
module zmap_out_stage #(
  parameter int P_W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [P_W-1:0] in_data,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [P_W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) out_data <= in_data;
  end

  // R7: accepted request yields a result next cycle
  p_load_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  // R8: stalled result holds
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/zoned_addr_mapper.sv
module zoned_addr_mapper
  import zmap_pkg::*;
#(
  parameter int ADDR_W = 16,
  localparam int LINE_W = ADDR_W - OFF_W,
  localparam int P_W = 2 + ADDR_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LINE_W-1:0] cfg_lines_a,
  input  logic [LINE_W-1:0] cfg_lines_b,
  output logic              cfg_bad,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [1:0]        res_sel,
  output logic [ADDR_W-1:0] res_local,
  output logic              res_sym,
  output logic              res_err
);
  logic [LINE_W:0]   sym_top;
  logic [LINE_W:0]   total;
  zone_e             zone;
  logic [1:0]        m_sel;
  logic [ADDR_W-1:0] m_local;
  logic              m_sym;
  logic              m_err;
  logic [P_W-1:0]    out_bus;

  zmap_cfg_check #(.LINE_W(LINE_W)) i_cfg (
    .lines_a(cfg_lines_a), .lines_b(cfg_lines_b),
    .bad(cfg_bad), .sym_top(sym_top), .total(total)
  );

  zmap_zone_classify #(.LINE_W(LINE_W)) i_zone (
    .line(req_addr[ADDR_W-1:OFF_W]), .sym_top(sym_top), .total(total),
    .bad(cfg_bad), .zone(zone)
  );

  zmap_addr_remap #(.ADDR_W(ADDR_W)) i_remap (
    .addr(req_addr), .zone(zone), .lines_b(cfg_lines_b),
    .sel(m_sel), .local_addr(m_local), .sym(m_sym), .err(m_err)
  );

  zmap_out_stage #(.P_W(P_W)) i_out (
    .clk(clk), .rst(rst),
    .in_valid(req_valid), .in_ready(req_ready),
    .in_data({m_sel, m_local, m_sym, m_err}),
    .out_valid(res_valid), .out_ready(res_ready),
    .out_data(out_bus)
  );

  assign {res_sel, res_local, res_sym, res_err} = out_bus;

  // R9: configuration frozen while traffic is in flight
  p_cfg_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (req_valid || res_valid) |-> ($stable(cfg_lines_a) && $stable(cfg_lines_b)));

  // R3: an error result never selects a channel
  p_err_nosel_r3: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_err) |-> (res_sel == SEL_NONE));

  // R4: invalid configuration always reports an error
  p_bad_err_r4: assert property (@(posedge clk) disable iff (rst)
    (res_valid && cfg_bad) |-> res_err);

  // R1: an interleaved result names exactly one channel
  p_sym_sel_r1: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_sym) |-> ($countones(res_sel) == 1 && !res_err));

  // R8: ready rule at the request side
  p_ready_r8: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> req_ready);
endmodule

// File: tb/test_zoned_addr_mapper.sv
module test_zoned_addr_mapper;
  localparam int ADDR_W = 10;
  localparam int LINE_W = ADDR_W - 6;
  localparam int NLINES = 1 << LINE_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [LINE_W-1:0] cfg_lines_a = '0;
  logic [LINE_W-1:0] cfg_lines_b = '0;
  logic              cfg_bad;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              res_valid;
  logic              res_ready = 1'b1;
  logic [1:0]        res_sel;
  logic [ADDR_W-1:0] res_local;
  logic              res_sym;
  logic              res_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  zoned_addr_mapper #(.ADDR_W(ADDR_W)) i_zoned_addr_mapper (
    .clk(clk), .rst(rst),
    .cfg_lines_a(cfg_lines_a), .cfg_lines_b(cfg_lines_b), .cfg_bad(cfg_bad),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .res_valid(res_valid), .res_ready(res_ready),
    .res_sel(res_sel), .res_local(res_local), .res_sym(res_sym), .res_err(res_err)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one transaction with expected result computed from the requirements
  task automatic txn(input int a, input int b, input int addr);
    int l, off, e_local;
    logic [1:0] e_sel;
    logic e_sym, e_err;
    string tag;
    l = addr >> 6;
    off = addr & 63;
    e_sel = 2'b00; e_local = 0; e_sym = 1'b0; e_err = 1'b0;
    if (b > a) begin
      e_err = 1'b1; tag = "R4";
    end else if (l >= a + b) begin
      e_err = 1'b1; tag = "R3";
    end else if (l < 2 * b) begin
      e_sel = ((addr >> 6) & 1) ? 2'b10 : 2'b01;
      e_local = ((l >> 1) << 6) | off;
      e_sym = 1'b1;
      tag = (a == b) ? "R6" : "R1";
    end else begin
      e_sel = 2'b01;
      e_local = ((l - b) << 6) | off;
      tag = (b == 0) ? "R5" : "R2";
    end
    @(negedge clk);
    req_valid = 1'b1;
    req_addr = addr[ADDR_W-1:0];
    @(negedge clk);
    req_valid = 1'b0;
    check("R7 res_valid", {31'd0, res_valid}, 32'd1);
    check(tag, {res_sel, res_local, res_sym, res_err},
          {e_sel, e_local[ADDR_W-1:0], e_sym, e_err});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R10 res_valid", {31'd0, res_valid}, 32'd0);
    check("R10 req_ready", {31'd0, req_ready}, 32'd1);

    for (int a = 0; a < NLINES; a++) begin
      for (int b = 0; b < NLINES; b++) begin
        @(negedge clk);
        cfg_lines_a = a[LINE_W-1:0];
        cfg_lines_b = b[LINE_W-1:0];
        @(negedge clk);
        check("R4 cfg_bad", {31'd0, cfg_bad}, (b > a) ? 32'd1 : 32'd0);
        for (int l = 0; l < NLINES; l++) begin
          txn(a, b, (l << 6) | ((l * 13 + a + b) & 63));
        end
      end
    end

    // back-pressure: a=5, b=3, line 7 -> linear zone, local line 4
    @(negedge clk);
    cfg_lines_a = 4'd5;
    cfg_lines_b = 4'd3;
    @(negedge clk);
    res_ready = 1'b0;
    req_valid = 1'b1;
    req_addr = 10'h1c5;
    @(negedge clk);
    req_addr = 10'h041;
    for (int k = 0; k < 4; k++) begin
      check("R8 req_ready", {31'd0, req_ready}, 32'd0);
      check("R8 held", {res_valid, res_sel, res_local, res_sym, res_err},
            {1'b1, 2'b01, 10'h105, 1'b0, 1'b0});
      @(negedge clk);
    end
    req_valid = 1'b0;
    res_ready = 1'b1;
    @(negedge clk);
    check("R8 drained", {31'd0, res_valid}, 32'd0);
    check("R8 ready idle", {31'd0, req_ready}, 32'd1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule